// File: doc/BRIEF.md
# Fixed-Point Result Epilogue Pipeline

This unit sits between the result drain of a matrix-multiply array and the memory write path. Every signed fixed-point word that leaves the array passes through a fixed chain of element-wise operations: a global gain, a per-column batch-norm multiply-and-add, ReLU, a rounding right shift and a clamp to a programmable window. Each operation is a stage that shares one stage interface. A compile-time mask decides which stages are built. A runtime mask register then lets any built stage pass its word through unchanged. A non-linear function such as sigmoid can later be added as one more stage without touching the array or its neighbours.

Words enter and leave on valid/ready streams. A word moves across an interface only in a cycle where valid and ready are both high. While the consumer holds `out_ready` low, the held output word stays fixed, and the stall spreads back stage by stage until it reaches `in_ready`. Each word carries a column index that selects its batch-norm pair. The index comes out alongside the result. Configuration is written one register per cycle through a plain write strobe with an address and data.

Top module: `pp_epilogue`

## Requirements
- R1: While `rst_n` is low and in the cycle after release, `out_valid` is 0. Registers reset to gain 1.0, batch-norm multiplier 1.0 and offset 0 for every column, shift 0, window [-32768, 32767], and all stages bypassed. With those values, enabling every stage changes a non-negative word in no way.
- R2: Latency is fixed at one cycle per built stage, whatever the bypass mask. With all five stages built, a word accepted on clock edge k appears on `out_valid` just after edge k+4.
- R3: While `out_valid` is high and `out_ready` is low, `out_data` and `out_col` hold their values. No word is dropped, duplicated or reordered under any pattern of back-pressure.
- R4: The gain stage computes floor(x·G / 256) and saturates it to 16 bits signed. G is a signed Q8.8 value.
- R5: The batch-norm stage computes floor(x·M[c] / 256) + A[c] and saturates it to 16 bits signed. M[c] (Q8.8) and A[c] are selected by the word's column index c.
- R6: The ReLU stage replaces negative words with 0 and passes the rest unchanged.
- R7: The round stage with shift s = 0 passes x unchanged. For s > 0 it returns floor((x + 2^(s-1)) / 2^s), which is round-half-up, and it has no intermediate overflow.
- R8: The clamp stage returns min(max(x, LO), HI). When LO > HI the result is HI.
- R9: Bypass mask bit 0 is gain, 1 is batch norm, 2 is ReLU, 3 is round and 4 is clamp. A 1 makes that stage pass its word unchanged.
- R10: Register addresses are 0x00 bypass mask (bits 4:0), 0x01 gain, 0x02 shift (bits 3:0), 0x03 LO, 0x04 HI, 0x10+c multiplier M[c] and 0x20+c offset A[c]. A write takes effect for words accepted by a stage on later clock edges.
- R11: The stages apply in the order gain, batch norm, ReLU, round, clamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Pipeline can accept a word |
| in_data | input | 16 | Signed input word |
| in_col | input | 2 | Column index of the input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 16 | Signed processed word |
| out_col | output | 2 | Column index that travelled with the word |

## Verification
A stage register that latched the wrong value shows a wrong `out_data` no later than the fifth edge after that word was accepted. A register that loses a word during a stall shows a gap in the sequence number the next time that word would have been released. If one stage's valid flag is wrong, a duplicated or missing word appears at the output once the pipeline drains. If the ready chain is wrong, a word changes while `out_ready` is low, and this is visible in the very next cycle. A misdecoded configuration register shows as a wrong value on the first word processed after the write.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [2:0] {
    OP_SCALE = 3'd0,
    OP_BNORM = 3'd1,
    OP_RELU  = 3'd2,
    OP_ROUND = 3'd3,
    OP_CLIP  = 3'd4
  } op_e;

  localparam int NUM_OPS = 5;
  localparam int ADDR_W  = 6;

  localparam logic [ADDR_W-1:0] REG_BYPASS = 6'h00;
  localparam logic [ADDR_W-1:0] REG_GAIN   = 6'h01;
  localparam logic [ADDR_W-1:0] REG_SHIFT  = 6'h02;
  localparam logic [ADDR_W-1:0] REG_LO     = 6'h03;
  localparam logic [ADDR_W-1:0] REG_HI     = 6'h04;
  localparam logic [ADDR_W-1:0] REG_BN_MUL = 6'h10;
  localparam logic [ADDR_W-1:0] REG_BN_ADD = 6'h20;
endpackage

// File: rtl/pp_op.sv
module pp_op
  import pp_pkg::*;
#(
  parameter op_e KIND = OP_SCALE,
  parameter int  DW   = 16,
  parameter int  FRAC = 8,
  parameter int  COLS = 4,
  parameter int  CW   = (COLS > 1) ? $clog2(COLS) : 1,
  parameter int  SW   = $clog2(DW)
) (
  input  logic signed [DW-1:0]           x,
  input  logic        [CW-1:0]           col,
  input  logic signed [DW-1:0]           gain,
  input  logic        [SW-1:0]           shamt,
  input  logic signed [DW-1:0]           lo,
  input  logic signed [DW-1:0]           hi,
  input  logic        [COLS-1:0][DW-1:0] bn_mul,
  input  logic        [COLS-1:0][DW-1:0] bn_add,
  output logic signed [DW-1:0]           y
);
  localparam int PW = 2 * DW + 1;
  localparam logic signed [PW-1:0] MAXV = $signed({{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [PW-1:0] MINV = ~MAXV;

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
    if (v > MAXV)      return MAXV[DW-1:0];
    else if (v < MINV) return MINV[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  logic signed [PW-1:0] p_gain, p_bn;
  logic signed [DW-1:0] m_sel, a_sel;
  logic signed [DW-1:0] y_gain, y_bn, y_relu, y_round, y_clip, floor_lo;
  logic signed [DW:0]   half, rsum;

  always_comb begin
    m_sel  = $signed(bn_mul[col]);
    a_sel  = $signed(bn_add[col]);
    p_gain = PW'(x) * PW'(gain);
    p_bn   = PW'(x) * PW'(m_sel);
    y_gain = sat(p_gain >>> FRAC);
    y_bn   = sat((p_bn >>> FRAC) + PW'(a_sel));
    y_relu = x[DW-1] ? '0 : x;
    // Round-half-up: add half an LSB of the result, then floor-shift.
    half   = (DW+1)'(1) << (shamt - SW'(1));
    rsum   = ((DW+1)'(x) + half) >>> shamt;
    y_round = (shamt == '0) ? x : rsum[DW-1:0];
    floor_lo = (x < lo) ? lo : x;
    y_clip = (floor_lo > hi) ? hi : floor_lo;
    case (KIND)
      OP_SCALE: y = y_gain;
      OP_BNORM: y = y_bn;
      OP_RELU:  y = y_relu;
      OP_ROUND: y = y_round;
      default:  y = y_clip;
    endcase
  end
endmodule

// File: rtl/pp_stage.sv
module pp_stage
  import pp_pkg::*;
#(
  parameter op_e KIND = OP_SCALE,
  parameter int  DW   = 16,
  parameter int  FRAC = 8,
  parameter int  COLS = 4,
  parameter int  CW   = (COLS > 1) ? $clog2(COLS) : 1,
  parameter int  SW   = $clog2(DW)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bypass,
  input  logic signed [DW-1:0]           gain,
  input  logic        [SW-1:0]           shamt,
  input  logic signed [DW-1:0]           lo,
  input  logic signed [DW-1:0]           hi,
  input  logic        [COLS-1:0][DW-1:0] bn_mul,
  input  logic        [COLS-1:0][DW-1:0] bn_add,
  input  logic                           i_valid,
  output logic                           i_ready,
  input  logic signed [DW-1:0]           i_data,
  input  logic        [CW-1:0]           i_col,
  output logic                           o_valid,
  input  logic                           o_ready,
  output logic signed [DW-1:0]           o_data,
  output logic        [CW-1:0]           o_col
);
  logic signed [DW-1:0] op_y;

  pp_op #(.KIND(KIND), .DW(DW), .FRAC(FRAC), .COLS(COLS), .CW(CW), .SW(SW)) u_op (
    .x(i_data), .col(i_col), .gain(gain), .shamt(shamt), .lo(lo), .hi(hi),
    .bn_mul(bn_mul), .bn_add(bn_add), .y(op_y)
  );

  // One register slice: load whenever empty or the downstream takes the word.
  assign i_ready = !o_valid || o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_col   <= '0;
    end else if (i_ready) begin
      o_valid <= i_valid;
      o_data  <= bypass ? i_data : op_y;
      o_col   <= i_col;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_col)); // R3

  AST_VALID_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_valid) |-> $past(i_valid)); // R2

  if (KIND == OP_RELU) begin : g_relu_chk
    logic act_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       act_q <= 1'b0;
      else if (i_ready) act_q <= i_valid && !bypass;
    end
    AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && act_q |-> !o_data[DW-1]); // R6
  end
endmodule

// File: rtl/pp_cfg.sv
module pp_cfg
  import pp_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int COLS = 4,
  parameter int SW   = $clog2(DW)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic        [ADDR_W-1:0]       addr,
  input  logic        [DW-1:0]           wdata,
  output logic        [NUM_OPS-1:0]      bypass,
  output logic signed [DW-1:0]           gain,
  output logic        [SW-1:0]           shamt,
  output logic signed [DW-1:0]           lo,
  output logic signed [DW-1:0]           hi,
  output logic        [COLS-1:0][DW-1:0] bn_mul,
  output logic        [COLS-1:0][DW-1:0] bn_add
);
  localparam logic [DW-1:0] ONE_Q = DW'(1) << FRAC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bypass <= '1;
      gain   <= ONE_Q;
      shamt  <= '0;
      lo     <= {1'b1, {(DW-1){1'b0}}};
      hi     <= {1'b0, {(DW-1){1'b1}}};
      for (int c = 0; c < COLS; c++) begin
        bn_mul[c] <= ONE_Q;
        bn_add[c] <= '0;
      end
    end else if (we) begin
      if (addr == REG_BYPASS) bypass <= wdata[NUM_OPS-1:0];
      if (addr == REG_GAIN)   gain   <= wdata;
      if (addr == REG_SHIFT)  shamt  <= wdata[SW-1:0];
      if (addr == REG_LO)     lo     <= wdata;
      if (addr == REG_HI)     hi     <= wdata;
      for (int c = 0; c < COLS; c++) begin
        if (addr == REG_BN_MUL + ADDR_W'(c)) bn_mul[c] <= wdata;
        if (addr == REG_BN_ADD + ADDR_W'(c)) bn_add[c] <= wdata;
      end
    end
  end

  AST_BYPASS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we && addr == REG_BYPASS |=> bypass == $past(wdata[NUM_OPS-1:0])); // R10
endmodule

// File: rtl/pp_epilogue.sv
module pp_epilogue
  import pp_pkg::*;
#(
  parameter int               DW      = 16,
  parameter int               FRAC    = 8,
  parameter int               COLS    = 4,
  parameter logic [4:0]       INCLUDE = 5'b11111,
  parameter int               CW      = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  input  logic [CW-1:0]        in_col,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_data,
  output logic [CW-1:0]        out_col
);
  localparam int SW = $clog2(DW);

  logic        [NUM_OPS-1:0]      bypass;
  logic signed [DW-1:0]           gain, lo, hi;
  logic        [SW-1:0]           shamt;
  logic        [COLS-1:0][DW-1:0] bn_mul, bn_add;

  pp_cfg #(.DW(DW), .FRAC(FRAC), .COLS(COLS), .SW(SW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .bypass(bypass), .gain(gain), .shamt(shamt), .lo(lo), .hi(hi),
    .bn_mul(bn_mul), .bn_add(bn_add)
  );

  logic [NUM_OPS:0]          v, r;
  logic [NUM_OPS:0][DW-1:0]  d;
  logic [NUM_OPS:0][CW-1:0]  c;

  assign v[0]       = in_valid;
  assign in_ready   = r[0];
  assign d[0]       = in_data;
  assign c[0]       = in_col;
  assign out_valid  = v[NUM_OPS];
  assign r[NUM_OPS] = out_ready;
  assign out_data   = $signed(d[NUM_OPS]);
  assign out_col    = c[NUM_OPS];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_stage
    if (INCLUDE[g]) begin : g_on
      logic signed [DW-1:0] s_out;
      pp_stage #(.KIND(op_e'(g)), .DW(DW), .FRAC(FRAC), .COLS(COLS), .CW(CW), .SW(SW)) u_stage (
        .clk(clk), .rst_n(rst_n), .bypass(bypass[g]),
        .gain(gain), .shamt(shamt), .lo(lo), .hi(hi), .bn_mul(bn_mul), .bn_add(bn_add),
        .i_valid(v[g]), .i_ready(r[g]), .i_data($signed(d[g])), .i_col(c[g]),
        .o_valid(v[g+1]), .o_ready(r[g+1]), .o_data(s_out), .o_col(c[g+1])
      );
      assign d[g+1] = s_out;
    end else begin : g_off
      assign v[g+1] = v[g];
      assign r[g]   = r[g+1];
      assign d[g+1] = d[g];
      assign c[g+1] = c[g];
    end
  end
endmodule

// File: tb/pp_epilogue_tb.sv
module pp_epilogue_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_data = '0;
  logic [1:0] in_col = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_data;
  logic [1:0] out_col;

  always #10 clk = ~clk;

  pp_epilogue u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_col(in_col),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_col(out_col)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [15:0] wd);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = wd;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Sends one word into an empty pipeline and returns the result and the edges taken.
  task automatic run_word(input logic signed [15:0] x, input logic [1:0] col,
                          output logic signed [15:0] y, output int edges);
    @(negedge clk);
    in_valid = 1'b1; in_data = x; in_col = col;
    edges = 0;
    @(posedge clk); edges++;
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid && edges < 20) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    y = out_data;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [4:0]         mask;
    logic [1:0]         col;
    logic signed [15:0] x;
    logic signed [15:0] exp;
  } vec_t;

  // Program: gain 1.5, BN c0 (2.0,+10) c1 (0.5,-20) c2 (-1.0,0) c3 (1.0,0x7000), shift 2, window [-50,300].
  localparam vec_t VECS [17] = '{
    '{5'h1F, 2'd0,  16'sd1234,  16'sd1234},  // R9 all bypassed
    '{5'h1E, 2'd0,  16'sd100,   16'sd150},   // R4
    '{5'h1E, 2'd0, -16'sd7,    -16'sd11},    // R4 floor
    '{5'h1E, 2'd0,  16'sd30000, 16'sd32767}, // R4 saturate
    '{5'h1D, 2'd1,  16'sd100,   16'sd30},    // R5
    '{5'h1D, 2'd3,  16'sd5000,  16'sd32767}, // R5 saturate
    '{5'h1D, 2'd0, -16'sd3,     16'sd4},     // R5
    '{5'h1B, 2'd0, -16'sd5,     16'sd0},     // R6
    '{5'h1B, 2'd0,  16'sd77,    16'sd77},    // R6
    '{5'h17, 2'd0,  16'sd6,     16'sd2},     // R7
    '{5'h17, 2'd0, -16'sd6,    -16'sd1},     // R7 half rounds up
    '{5'h17, 2'd0, -16'sd7,    -16'sd2},     // R7
    '{5'h0F, 2'd0,  16'sd400,   16'sd300},   // R8
    '{5'h0F, 2'd0, -16'sd60,   -16'sd50},    // R8
    '{5'h00, 2'd0, -16'sd40,    16'sd0},     // R11
    '{5'h00, 2'd2, -16'sd40,    16'sd15},    // R11
    '{5'h00, 2'd0,  16'sd1000,  16'sd300}    // R11 clamp after round
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic signed [15:0] y;
    int edges;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);

    // R1 reset values are identity with every stage enabled.
    cfg_write(6'h00, 16'h0000);
    run_word(16'sd123, 2'd1, y, edges);
    chk("R1 identity config", int'(y), 123);

    // R10 register map
    cfg_write(6'h01, 16'h0180);
    cfg_write(6'h02, 16'd2);
    cfg_write(6'h03, 16'hFFCE);
    cfg_write(6'h04, 16'd300);
    cfg_write(6'h10, 16'h0200); cfg_write(6'h20, 16'd10);
    cfg_write(6'h11, 16'h0080); cfg_write(6'h21, 16'hFFEC);
    cfg_write(6'h12, 16'hFF00); cfg_write(6'h22, 16'h0000);
    cfg_write(6'h13, 16'h0100); cfg_write(6'h23, 16'h7000);

    foreach (VECS[i]) begin
      cfg_write(6'h00, {11'd0, VECS[i].mask});
      run_word(VECS[i].x, VECS[i].col, y, edges);
      chk($sformatf("R4-R11 vector %0d", i), int'(y), int'(VECS[i].exp));
    end

    // R2 latency fixed regardless of bypass
    cfg_write(6'h00, 16'h0000);
    run_word(16'sd10, 2'd0, y, edges);
    chk("R2 latency all active", edges, 5);
    cfg_write(6'h00, 16'h001F);
    run_word(16'sd10, 2'd0, y, edges);
    chk("R2 latency all bypassed", edges, 5);

    // R10 gain rewrite applies to later words
    cfg_write(6'h01, 16'h0200);
    cfg_write(6'h00, 16'h001E);
    run_word(16'sd100, 2'd0, y, edges);
    chk("R10 gain rewrite", int'(y), 200);

    // R3 back-pressure: 8 words through a bypassed pipeline
    cfg_write(6'h00, 16'h001F);
    begin
      int sent = 0;
      int got = 0;
      logic prev_stall = 1'b0;
      logic signed [15:0] prev_data = '0;
      for (int cyc = 0; cyc < 200 && got < 8; cyc++) begin
        @(negedge clk);
        out_ready = !(cyc >= 3 && cyc < 10) && (cyc % 3 != 0);
        in_valid  = (sent < 8);
        in_data   = 16'(sent + 1);
        in_col    = 2'(sent);
        #1;
        if (prev_stall) begin
          chk("R3 held valid", int'(out_valid), 1);
          chk("R3 held data", int'(out_data), int'(prev_data));
        end
        if (in_valid && in_ready) sent++;
        if (out_valid && out_ready) begin
          chk("R3 order", int'(out_data), got + 1);
          chk("R3 column", int'(out_col), got % 4);
          got++;
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      chk("R3 word count", got, 8);
      begin
        int extra = 0;
        repeat (10) begin
          @(negedge clk);
          if (out_valid) extra++;
        end
        chk("R3 no duplicate", extra, 0);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule